// File: doc/BRIEF.md
# Indirect Global Register Access Window

This block opens a large global register space to three requesters through a small window. Each requester has its own pair of window registers. The first holds a DWord address into the global space. The second is a data port: reading it returns the global register at that address, and writing it updates that register. The three requesters are the configuration-request path (index 0), the SMBus-side path (index 1) and the serial-EEPROM loader path (index 2). They share one internal register bus.

A fixed-priority arbiter grants the bus to one requester per cycle. Each granted access is acknowledged one cycle later, with its read data and error flags. Two checks apply to data-port accesses:
- A protection control can block the configuration path. The other two paths ignore it.
- Byte enables are checked against the native size of the target register.

The register file is modelled as an internal memory. Addresses at or above the implemented count are reserved.

Top module: `gspace_window`

## Requirements
- R1: Each requester has its own address register, ADDR_W bits wide, which resets to 0. A window-select-0 write stores wdata[ADDR_W-1:0], and a window-select-0 read returns the stored value zero-extended. Address-register accesses ignore byte enables and protection, and never raise an error flag.
- R2: A data-port read (select 1) returns the register at the stored address. A DWord register returns all 32 bits. A byte-sized register returns its value in bits 7:0 with bits 31:8 zero.
- R3: A legal data-port write updates the selected register. A DWord register takes all of wdata. A byte-sized register takes the byte from the single enabled lane, or bits 7:0 when all four enables are set.
- R4: Every address below NUM_REGS is a readable and writable register. The byte-sized registers are those whose address has bits [1:0] equal to 2'b11; all others are DWord-sized.
- R5: Addresses at or above NUM_REGS are reserved. A read returns 0. A write is acknowledged without an error flag and changes no register.
- R6: While prot_en is 1, a data-port access from requester 0 is still acknowledged, but it returns 0, drops any write and pulses err_prot[0]. Requesters 1 and 2 behave the same whether prot_en is 0 or 1.
- R7: A byte-sized register accepts exactly one byte enable set, or all four set. A DWord register accepts only 4'b1111. Any other pattern pulses err_size with the ack, returns 0 and leaves the register unchanged. A blocked protected access reports only err_prot.
- R8: Arbitration is fixed priority, index 0 first, then 1, then 2. At most one ack bit is high in any cycle. A requester whose ack bit is high is not granted in that cycle.
- R9: A requester granted at a clock edge sees its ack bit high for exactly the following cycle. The rd_data, err_size and err_prot values are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protection control that blocks data-port access on the configuration path |
| req_vld | input | 3 | Access request, one bit per requester |
| req_sel | input | 3 | Window register select per requester: 0 = address register, 1 = data port |
| req_wr | input | 3 | 1 = write, 0 = read, per requester |
| req_wdata | input | 3x32 | Write data per requester |
| req_be | input | 3x4 | Byte enables per requester |
| ack | output | 3 | One-cycle completion per requester |
| rd_data | output | 32 | Read data of the acknowledged access |
| err_size | output | 3 | Byte-enable / native-size violation, with ack |
| err_prot | output | 3 | Protection violation, with ack |

## Verification
The bench uses the default parameters: ADDR_W = 6 and NUM_REGS = 48. This gives 48 real registers and a 16-entry reserved band in a space small enough to sweep completely. Twelve of the registers are byte-sized, so every byte-lane and size-legality case falls on addresses that a full sweep and a random run both reach many times. Because the space is this small, random addresses regularly land on reserved entries and on registers that an earlier random write has already changed.

// File: rtl/gwin_pkg.sv
package gwin_pkg;
    localparam int NREQ = 3;
    localparam int DW   = 32;
    localparam int BEW  = DW / 8;

    // Legal byte-enable pattern for a register of the given native size.
    function automatic logic be_legal(input logic [BEW-1:0] be, input logic is_byte);
        if (be == {BEW{1'b1}}) return 1'b1;
        if (is_byte)           return ($countones(be) == 1);
        return 1'b0;
    endfunction

    // Byte that a byte-sized register takes from a legal write.
    function automatic logic [7:0] lane_byte(input logic [DW-1:0] wd, input logic [BEW-1:0] be);
        logic [7:0] r;
        r = wd[7:0];
        for (int i = 0; i < BEW; i++) begin
            if (be == BEW'(1 << i)) r = wd[8*i +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/gwin_arb.sv
module gwin_arb #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gwin_regfile.sv
module gwin_regfile #(
    parameter int DW = 32,
    parameter int AW = 6,
    parameter int NUM_REGS = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(NUM_REGS);

    logic [DW-1:0] mem_d [NUM_REGS];
    logic [DW-1:0] mem_q [NUM_REGS];
    logic          hit;

    assign hit = ({1'b0, addr} < LIMIT);

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) mem_d[i] = mem_q[i];
        if (we && hit) mem_d[addr] = wdata;
        rdata = hit ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= mem_d[i];
        end
    end

    AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> hit); // R5
endmodule

// File: rtl/gspace_window.sv
module gspace_window
    import gwin_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_REGS = 48,
    parameter logic [NREQ-1:0] PROT_MASK = 3'b001
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prot_en,
    input  logic [NREQ-1:0]           req_vld,
    input  logic [NREQ-1:0]           req_sel,
    input  logic [NREQ-1:0]           req_wr,
    input  logic [NREQ-1:0][DW-1:0]   req_wdata,
    input  logic [NREQ-1:0][BEW-1:0]  req_be,
    output logic [NREQ-1:0]           ack,
    output logic [DW-1:0]             rd_data,
    output logic [NREQ-1:0]           err_size,
    output logic [NREQ-1:0]           err_prot
);
    localparam int IW = $clog2(NREQ);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

    typedef struct packed {
        logic [NREQ-1:0][ADDR_W-1:0] addr;
        logic [NREQ-1:0]             ack;
        logic [NREQ-1:0]             esize;
        logic [NREQ-1:0]             eprot;
        logic [DW-1:0]               rdata;
    } st_t;

    st_t s_d, s_q;

    logic [NREQ-1:0]   gnt;
    logic [IW-1:0]     gidx;
    logic              g_any;
    logic [ADDR_W-1:0] tgt;
    logic              tgt_byte, tgt_rsv, blocked;
    logic [BEW-1:0]    cur_be;
    logic [DW-1:0]     cur_wd;
    logic              rf_we;
    logic [DW-1:0]     rf_wdata, rf_rdata;

    // A requester being acknowledged this cycle is masked out of arbitration.
    gwin_arb #(.N(NREQ)) u_arb (
        .req (req_vld & ~s_q.ack),
        .gnt (gnt),
        .idx (gidx),
        .any (g_any)
    );

    gwin_regfile #(.DW(DW), .AW(ADDR_W), .NUM_REGS(NUM_REGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (tgt),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ack   = '0;
        s_d.esize = '0;
        s_d.eprot = '0;
        s_d.rdata = '0;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        tgt       = s_q.addr[gidx];
        tgt_byte  = (tgt[1:0] == 2'b11);
        tgt_rsv   = !({1'b0, tgt} < LIMIT);
        cur_be    = req_be[gidx];
        cur_wd    = req_wdata[gidx];
        blocked   = PROT_MASK[gidx] & prot_en;
        if (g_any) begin
            s_d.ack = gnt;
            if (!req_sel[gidx]) begin
                if (req_wr[gidx]) s_d.addr[gidx] = cur_wd[ADDR_W-1:0];
                else              s_d.rdata      = DW'(s_q.addr[gidx]);
            end else if (blocked) begin
                s_d.eprot[gidx] = 1'b1;
            end else if (!be_legal(cur_be, tgt_byte)) begin
                s_d.esize[gidx] = 1'b1;
            end else if (req_wr[gidx]) begin
                rf_we    = !tgt_rsv;
                rf_wdata = tgt_byte ? {{(DW-8){1'b0}}, lane_byte(cur_wd, cur_be)} : cur_wd;
            end else if (!tgt_rsv) begin
                s_d.rdata = tgt_byte ? {{(DW-8){1'b0}}, rf_rdata[7:0]} : rf_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ack      = s_q.ack;
    assign rd_data  = s_q.rdata;
    assign err_size = s_q.esize;
    assign err_prot = s_q.eprot;

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack)); // R8
    AST_CFG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[0] && !ack[0]) |=> ack[0]); // R8
    AST_SMB_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld[1] && !ack[1] && !(req_vld[0] && !ack[0])) |=> ack[1]); // R8
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack[2] |=> !ack[2]); // R9
    AST_PROT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prot != '0) |-> ($past(prot_en) && err_prot[0] && rd_data == '0)); // R6
    AST_SIZE_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (err_size != '0) |-> (err_size == ack && rd_data == '0 && err_prot == '0)); // R7
endmodule

// File: tb/tb_gspace_window.sv
`timescale 1ns/1ps
module tb_gspace_window;
    localparam int AW = 6;
    localparam int NR = 48;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prot_en = 1'b0;
    logic [2:0]       req_vld = '0, req_sel = '0, req_wr = '0;
    logic [2:0][31:0] req_wdata = '0;
    logic [2:0][3:0]  req_be = '0;
    logic [2:0]       ack, err_size, err_prot;
    logic [31:0]      rd_data;

    int tests = 0, fails = 0;
    logic [31:0]   m [64];
    logic [AW-1:0] am [3];

    always #5 clk = ~clk;

    gspace_window dut (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .req_vld(req_vld),
        .req_sel(req_sel), .req_wr(req_wr), .req_wdata(req_wdata), .req_be(req_be),
        .ack(ack), .rd_data(rd_data), .err_size(err_size), .err_prot(err_prot)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input logic [3:0] be, input bit byt);
        if (be == 4'hF) return 1'b1;
        return byt && ($countones(be) == 1);
    endfunction

    function automatic logic [7:0] pick(input logic [31:0] wd, input logic [3:0] be);
        case (be)
            4'b0010: return wd[15:8];
            4'b0100: return wd[23:16];
            4'b1000: return wd[31:24];
            default: return wd[7:0];
        endcase
    endfunction

    // One access from requester r, checked against the reference model.
    task automatic acc(input int r, input bit sel, input bit wr, input logic [31:0] wd,
                       input logic [3:0] be, input bit pe, input string tag);
        logic [31:0] er;
        bit ep, es;
        logic [AW-1:0] a;
        er = '0; ep = 0; es = 0; a = am[r];
        if (!sel) begin
            if (wr) am[r] = wd[AW-1:0];
            else    er = 32'(a);
        end else if (r == 0 && pe) begin
            ep = 1;
        end else if (!legal(be, a[1:0] == 2'b11)) begin
            es = 1;
        end else if (wr) begin
            if (a < NR) m[a] = (a[1:0] == 2'b11) ? {24'b0, pick(wd, be)} : wd;
        end else begin
            er = (a < NR) ? m[a] : 32'h0;
        end
        @(negedge clk);
        prot_en = pe;
        req_vld[r] = 1'b1; req_sel[r] = sel; req_wr[r] = wr;
        req_wdata[r] = wd; req_be[r] = be;
        @(posedge clk); #1;
        chk(ack == 3'(1 << r), {tag, " R9 ack"}, 32'(ack), 32'(1 << r));
        chk(rd_data == er, {tag, " data"}, rd_data, er);
        chk(err_prot[r] == ep, {tag, " R6 prot flag"}, 32'(err_prot), 32'(ep));
        chk(err_size[r] == es, {tag, " R7 size flag"}, 32'(err_size), 32'(es));
        @(negedge clk);
        req_vld = '0;
    endtask

    initial begin
        #1_000_000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) m[i] = '0;
        for (int i = 0; i < 3; i++) am[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(ack == 0 && err_size == 0 && err_prot == 0 && rd_data == 0, "R9 reset outputs", 32'(ack), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1: address registers reset to 0, are independent and ignore protection
        for (int r = 0; r < 3; r++) acc(r, 0, 0, 0, 4'h0, 1, "R1 addr reset");
        acc(0, 0, 1, 32'hFFFF_FF2A, 4'h0, 1, "R1 addr wr");
        acc(1, 0, 1, 32'h0000_0011, 4'h1, 0, "R1 addr wr");
        acc(0, 0, 0, 0, 4'h0, 1, "R1 addr rd");
        acc(1, 0, 0, 0, 4'h0, 0, "R1 addr rd");

        // R4/R3/R2/R5: sweep the whole space from the EEPROM path
        for (int a = 0; a < 64; a++) begin
            acc(2, 0, 1, 32'(a), 4'hF, 0, "R4 sweep addr");
            acc(2, 1, 1, 32'hA5000000 ^ (32'(a) * 32'h01010101), 4'hF, 0, "R3 sweep wr");
        end
        for (int a = 0; a < 64; a++) begin
            acc(2, 0, 1, 32'(a), 4'hF, 0, "R4 sweep addr");
            acc(2, 1, 0, 0, 4'hF, 0, "R2 R5 sweep rd");
        end

        // R3: byte register lane selection; R7: illegal patterns
        acc(1, 0, 1, 32'd7, 4'hF, 0, "R4 byte reg");
        acc(1, 1, 1, 32'h11223344, 4'b0100, 0, "R3 lane2");
        acc(1, 1, 0, 0, 4'b0001, 0, "R2 byte rd");
        acc(1, 1, 1, 32'h99887766, 4'b0011, 0, "R7 two lanes");
        acc(1, 1, 0, 0, 4'hF, 0, "R7 unchanged");
        acc(1, 0, 1, 32'd6, 4'hF, 0, "R4 dword reg");
        acc(1, 1, 1, 32'hDEAD_BEEF, 4'b0001, 0, "R7 dword single");
        acc(1, 1, 1, 32'hDEAD_BEEF, 4'b0000, 0, "R7 none");
        acc(1, 1, 0, 0, 4'hF, 0, "R7 unchanged");

        // R6: protection hits only the configuration path
        acc(0, 0, 1, 32'd6, 4'hF, 1, "R6 addr");
        acc(0, 1, 1, 32'h0BAD_0BAD, 4'h1, 1, "R6 blocked wr");
        acc(0, 1, 0, 0, 4'hF, 1, "R6 blocked rd");
        acc(1, 1, 1, 32'h1357_2468, 4'hF, 1, "R6 smbus free");
        acc(2, 0, 1, 32'd6, 4'hF, 1, "R6 addr");
        acc(2, 1, 0, 0, 4'hF, 1, "R6 eeprom free");
        acc(0, 1, 0, 0, 4'hF, 0, "R6 cfg unblocked");

        // R8: all three request together; grants come 0, 1, 2
        @(negedge clk);
        req_sel = '0; req_wr = '0; req_vld = 3'b111;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk(ack == 3'(1 << k), "R8 priority order", 32'(ack), 32'(1 << k));
            chk(rd_data == 32'(am[k]), "R8 granted data", rd_data, 32'(am[k]));
            @(negedge clk);
            req_vld[k] = 1'b0;
        end
        // R8: a held top-priority request yields one cycle to the next
        @(negedge clk);
        req_vld = 3'b011;
        @(posedge clk); #1;
        chk(ack == 3'b001, "R8 held first", 32'(ack), 1);
        @(posedge clk); #1;
        chk(ack == 3'b010, "R8 masked after ack", 32'(ack), 2);
        @(negedge clk);
        req_vld = '0;
        @(posedge clk); #1;

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [3:0] be;
            r = int'($urandom_range(2, 0));
            case ($urandom_range(3, 0))
                0: be = 4'hF;
                1: be = 4'(1 << $urandom_range(3, 0));
                default: be = 4'($urandom);
            endcase
            if ($urandom_range(2, 0) == 0)
                acc(r, 0, 1, $urandom, be, 1'($urandom), "R1 rnd addr");
            else
                acc(r, 1, 1'($urandom), $urandom, be, 1'($urandom), "R2 R3 R6 R7 rnd");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule